// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block gathers interrupt requests from four peripheral sources into one request line for a small 4-bit CPU. Each source owns a pending flag that its hardware sets with a one-cycle strobe. While the global enable is high, the highest-ranked pending source is registered as the winner and presented to the CPU with its vector address. The CPU accepts it with an acknowledge pulse, and that clears the winner's flag.

Software sees the four pending flags as a status word and can drop any of them through a write-one-to-clear port. The arbitration order is not fixed. It is a table of four ranks, each holding a 2-bit source number. The table is loaded two ranks at a time through 4-bit configuration writes, so the CPU can put any source ahead of the others.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A high bit of `src_set` at a clock edge sets the matching pending flag, and the flag shows on `stat_q` after that edge. All flags are 0 after reset.
- R2: When `clr_we` is high, each 1 in `clr_data` clears the matching flag at the next edge. Each 0 in `clr_data` leaves its flag unchanged.
- R3: A set strobe on a flag wins over a software clear or an acknowledge that hits the same flag in the same cycle, so the flag stays 1.
- R4: The rank table has two 4-bit write ports, selected by `pri_we[0]` and `pri_we[1]`. Port 0 holds rank 1 (the highest) in bits [1:0] and rank 2 in bits [3:2]. Port 1 holds rank 3 in bits [1:0] and rank 4 in bits [3:2]. After reset the ranks are 0,1,2,3 in order. For example, 0x2 in port 0 and 0xD in port 1 give the order 2,0,1,3.
- R5: While no request is presented, the block registers the pending source with the best rank. `irq_req` rises one edge after the flags show a pending source, and only if `glob_en` was high at that edge.
- R6: A presented request holds `irq_req`, `irq_id` and `irq_vec` stable until `ack` is sampled high. At that edge the winner's flag clears and `irq_req` falls. Arbitration resumes at the following edge. An `ack` that arrives while `irq_req` is low has no effect.
- R7: `irq_vec` is 0x0001, 0x0002, 0x0003 or 0x0004 for source 0, 1, 2 or 3, and always matches `irq_id`.
- R8: A source whose number appears in no rank of the table never wins, even when its flag is set. This is the case when the table holds duplicate entries.
- R9: Flags that build up while `glob_en` is low are served one by one in rank order once `glob_en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 4 | Set strobes from the four sources |
| glob_en | input | 1 | Global interrupt enable |
| ack | input | 1 | CPU acceptance pulse |
| clr_we | input | 1 | Software clear write strobe |
| clr_data | input | 4 | Write-one-to-clear mask |
| pri_we | input | 2 | Rank port write strobes (bit 0: ranks 1–2, bit 1: ranks 3–4) |
| pri_wdata | input | 4 | Rank port write data |
| stat_q | output | 4 | Pending flags, 1 = request pending |
| irq_req | output | 1 | Request presented to the CPU |
| irq_id | output | 2 | Source number of the presented request |
| irq_vec | output | 16 | Vector address of the presented request |

## Verification
Three events can land on one pending flag in the same cycle: a new set strobe, a software clear and the CPU acknowledge. The bench drives them together on purpose. It pulses `src_set` in the cycle where `ack` accepts that same source, and in the cycle where `clr_data` names it. It then checks that the flag survives and that the source is presented again. A cycle-accurate behavioural model compares the status word, request, source number and vector on every clock. Other cases it covers are rank reprogramming while flags are pending, and a duplicate table that hides one source.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC    = 4;
  localparam int unsigned IDW     = $clog2(NSRC);
  localparam int unsigned PORTW   = 4;
  localparam int unsigned VECW    = 16;
  localparam int unsigned RPP     = PORTW / IDW;   // ranks per port
  localparam int unsigned NPORT   = NSRC / RPP;

  function automatic logic [VECW-1:0] vec_of(input logic [IDW-1:0] id);
    return VECW'(id) + VECW'(1);
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[i] <= 1'b0;
      else if (set_i[i])
        flag_q[i] <= 1'b1;
      else if (clr_i[i] || take_i[i])
        flag_q[i] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_rank_table.sv
module irq_rank_table #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDW   = 2,
  parameter int unsigned PORTW = 4,
  localparam int unsigned NPORT = (N * IDW) / PORTW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORT-1:0]   we_i,
  input  logic [PORTW-1:0]   wdata_i,
  output logic [N*IDW-1:0]   rank_o
);
  logic [N*IDW-1:0] rank_q;
  logic [N*IDW-1:0] rank_rst;

  for (genvar l = 0; l < N; l++) begin : g_ident
    assign rank_rst[l*IDW +: IDW] = IDW'(l);
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)
        rank_q[p*PORTW +: PORTW] <= rank_rst[p*PORTW +: PORTW];
      else if (we_i[p])
        rank_q[p*PORTW +: PORTW] <= wdata_i;
    end
  end

  assign rank_o = rank_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N    = 4,
  parameter int unsigned IDW  = 2,
  parameter int unsigned VECW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     flag_i,
  input  logic [N*IDW-1:0] rank_i,
  input  logic             en_i,
  input  logic             ack_i,
  output logic [N-1:0]     take_o,
  output logic             req_o,
  output logic [IDW-1:0]   id_o,
  output logic [VECW-1:0]  vec_o
);
  logic           hit;
  logic [IDW-1:0] win;
  logic           req_q;
  logic [IDW-1:0] id_q;
  logic [VECW-1:0] vec_q;

  // Walk from the lowest rank up so the best rank overrides.
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int l = N - 1; l >= 0; l--) begin
      if (flag_i[rank_i[l*IDW +: IDW]]) begin
        hit = 1'b1;
        win = rank_i[l*IDW +: IDW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      id_q  <= '0;
      vec_q <= irq_pkg::vec_of('0);
    end else if (req_q) begin
      if (ack_i) req_q <= 1'b0;
    end else begin
      req_q <= en_i && hit;
      if (hit) begin
        id_q  <= win;
        vec_q <= irq_pkg::vec_of(win);
      end
    end
  end

  always_comb begin
    take_o = '0;
    if (req_q && ack_i) take_o[id_q] = 1'b1;
  end

  assign req_o = req_q;
  assign id_o  = id_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = NSRC
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_SRC-1:0]          src_set,
  input  logic                      glob_en,
  input  logic                      ack,
  input  logic                      clr_we,
  input  logic [N_SRC-1:0]          clr_data,
  input  logic [(N_SRC*IDW)/PORTW-1:0] pri_we,
  input  logic [PORTW-1:0]          pri_wdata,
  output logic [N_SRC-1:0]          stat_q,
  output logic                      irq_req,
  output logic [IDW-1:0]            irq_id,
  output logic [VECW-1:0]           irq_vec
);
  logic [N_SRC-1:0]     take;
  logic [N_SRC*IDW-1:0] rank;
  logic [N_SRC-1:0]     clr_mask;

  assign clr_mask = clr_we ? clr_data : '0;

  irq_flag_bank #(.N(N_SRC)) u_flags (
    .clk(clk), .rst(rst), .set_i(src_set), .clr_i(clr_mask),
    .take_i(take), .flag_o(stat_q)
  );

  irq_rank_table #(.N(N_SRC), .IDW(IDW), .PORTW(PORTW)) u_rank (
    .clk(clk), .rst(rst), .we_i(pri_we), .wdata_i(pri_wdata), .rank_o(rank)
  );

  irq_arbiter #(.N(N_SRC), .IDW(IDW), .VECW(VECW)) u_arb (
    .clk(clk), .rst(rst), .flag_i(stat_q), .rank_i(rank), .en_i(glob_en),
    .ack_i(ack), .take_o(take), .req_o(irq_req), .id_o(irq_id), .vec_o(irq_vec)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] src_set,
  input logic         glob_en,
  input logic         ack,
  input logic         clr_we,
  input logic [N-1:0] clr_data,
  input logic [N-1:0] stat_q,
  input logic         irq_req,
  input logic [1:0]   irq_id,
  input logic [15:0]  irq_vec
);
  // R1
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (src_set != '0) |=> ((stat_q & $past(src_set)) == $past(src_set)));

  // R2
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((stat_q & $past(clr_data & ~src_set)) == '0));

  // R5
  rise_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(glob_en));

  // R6
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !ack) |=> (irq_req && $stable(irq_id) && $stable(irq_vec)));

  // R6
  ack_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && ack) |=> !irq_req);

  // R7
  vec_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec == 16'(irq_id) + 16'd1));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .src_set(src_set), .glob_en(glob_en), .ack(ack),
  .clr_we(clr_we), .clr_data(clr_data), .stat_q(stat_q), .irq_req(irq_req),
  .irq_id(irq_id), .irq_vec(irq_vec)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] src_set = '0;
  logic       glob_en = 1'b0;
  logic       ack = 1'b0;
  logic       clr_we = 1'b0;
  logic [3:0] clr_data = '0;
  logic [1:0] pri_we = '0;
  logic [3:0] pri_wdata = '0;
  logic [3:0] stat_q;
  logic       irq_req;
  logic [1:0] irq_id;
  logic [15:0] irq_vec;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .src_set(src_set), .glob_en(glob_en), .ack(ack),
    .clr_we(clr_we), .clr_data(clr_data), .pri_we(pri_we), .pri_wdata(pri_wdata),
    .stat_q(stat_q), .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec)
  );

  always #2 clk = ~clk;   // 250 MHz

  // Behavioural reference model
  int m_flag[4];
  int m_rank[4];
  int m_req, m_id;
  int vectors = 0, bad = 0, cycles = 0;
  string tag = "R1";

  always @(posedge clk) begin
    int win, found;
    int nf[4];
    if (rst) begin
      foreach (m_flag[i]) begin m_flag[i] = 0; m_rank[i] = i; end
      m_req = 0; m_id = 0;
    end else begin
      found = 0; win = 0;
      for (int l = 0; l < 4; l++)
        if (!found && m_flag[m_rank[l]] != 0) begin found = 1; win = m_rank[l]; end
      for (int i = 0; i < 4; i++) begin
        nf[i] = m_flag[i];
        if ((clr_we && clr_data[i]) || (ack && m_req != 0 && m_id == i)) nf[i] = 0;
        if (src_set[i]) nf[i] = 1;
      end
      if (m_req != 0) begin
        if (ack) m_req = 0;
      end else begin
        m_req = (glob_en && found != 0) ? 1 : 0;
        if (found != 0) m_id = win;
      end
      foreach (m_flag[i]) m_flag[i] = nf[i];
      if (pri_we[0]) begin m_rank[0] = pri_wdata & 3; m_rank[1] = pri_wdata >> 2; end
      if (pri_we[1]) begin m_rank[2] = pri_wdata & 3; m_rank[3] = pri_wdata >> 2; end
    end
  end

  always @(negedge clk) begin
    int es;
    cycles++;
    es = 0;
    for (int i = 0; i < 4; i++) es |= (m_flag[i] << i);
    vectors++;
    if (stat_q !== 4'(es) || irq_req !== 1'(m_req) ||
        (m_req != 0 && (irq_id !== 2'(m_id) || irq_vec !== 16'(m_id + 1)))) begin
      bad++;
      $display("FAIL %s: got stat=%h req=%b id=%0d vec=%h, want stat=%h req=%0d id=%0d vec=%h",
               tag, stat_q, irq_req, irq_id, irq_vec, es, m_req, m_id, m_id + 1);
    end
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_set(logic [3:0] m);
    src_set = m; tick(); src_set = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic load_rank(logic [3:0] p0, logic [3:0] p1);
    bit seen[4];
    int dup = 0;
    int r[4];
    r[0] = p0[1:0]; r[1] = p0[3:2]; r[2] = p1[1:0]; r[3] = p1[3:2];
    foreach (r[i]) begin if (seen[r[i]]) dup = 1; seen[r[i]] = 1; end
    if (dup != 0) $display("NOTE: rank table %h/%h is a configuration error (duplicate ids)", p0, p1);
    pri_we = 2'b01; pri_wdata = p0; tick();
    pri_we = 2'b10; pri_wdata = p1; tick();
    pri_we = '0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);                                   // R1 reset state

    tag = "R1/R7"; glob_en = 1'b1;
    for (int s = 0; s < 4; s++) begin strobe_set(4'(1 << s)); tick(2); do_ack(); tick(2); end

    tag = "R5"; strobe_set(4'hF); tick(2);     // R4 identity order
    repeat (4) begin do_ack(); tick(2); end

    tag = "R6"; do_ack(); tick(2);             // ack with nothing presented

    tag = "R4"; load_rank(4'h2, 4'hD);         // order 2,0,1,3
    tag = "R9"; glob_en = 1'b0; strobe_set(4'hB); strobe_set(4'h4); tick(3);
    glob_en = 1'b1; tick(2);
    repeat (4) begin tick(3); do_ack(); end
    tick(2);

    tag = "R2"; glob_en = 1'b0; strobe_set(4'hF);
    clr_we = 1'b1; clr_data = 4'h5; tick(); clr_we = 1'b0; tick();
    clr_we = 1'b1; clr_data = 4'h0; tick(); clr_we = 1'b0; tick();
    clr_we = 1'b1; clr_data = 4'hF; tick(); clr_we = 1'b0; tick();

    tag = "R3"; src_set = 4'h2; clr_we = 1'b1; clr_data = 4'h2; tick();
    src_set = '0; clr_we = 1'b0; tick();
    glob_en = 1'b1; tick(3);
    src_set = 4'h2; ack = 1'b1; tick(); src_set = '0; ack = 1'b0; tick(3);
    do_ack(); tick(2);

    tag = "R8"; load_rank(4'h0, 4'h0);         // every rank names source 0
    strobe_set(4'h8); tick(4);
    strobe_set(4'h1); tick(3); do_ack(); tick(3);
    clr_we = 1'b1; clr_data = 4'hF; tick(); clr_we = 1'b0;
    load_rank(4'hE, 4'h4);                    // order 2,3,0,1
    tag = "R4"; strobe_set(4'hF); tick(2);
    repeat (4) begin do_ack(); tick(2); end

    tag = "R1"; rst = 1'b1; tick(2); rst = 1'b0; tick(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule